// File: doc/BRIEF.md
# Peripheral Interrupt Register Block

This block holds the interrupt logic of a single peripheral with eight interrupt sources. Each raw source input passes through one register stage. It then goes to a detector that works per source. Each source can be edge-triggered or level-triggered. Sensitivity to the high side and the low side is enabled separately, so in edge mode rising edges, falling edges or both can be caught. A detected event sets a sticky latch bit. Software clears that bit by writing ones to a clear register.

Enables are never written directly. One register sets enable bits where a one is written, and a second register clears them. The block drives one registered request line toward an upstream arbiter. The request is high while any latched source is also enabled. Software reaches every register through a byte-addressed read/write port with a registered read result.

Top module: `pir_block`

## Requirements
- R1: After synchronous reset every register reads zero and `irq_req` is low.
- R2: A read of offset 0x10 returns the raw inputs as seen after one register stage.
- R3: Offsets 0x11 (type, 1 = edge, 0 = level), 0x12 (high-side enable) and 0x13 (low-side enable) are plain read/write registers.
- R4: In edge mode, a source with its high-side bit set latches on a rising input. A source without that bit does not latch on a rising input.
- R5: In edge mode, a source with its low-side bit set latches on a falling input. With both bits set, both edges latch.
- R6: In level mode, the latch sets while the input is high (high-side bit) or low (low-side bit). A clear has no lasting effect while that level persists. Once the level is gone, a clear releases the latch.
- R7: Writing to offset 0x14 clears each latch bit where the written data has a one. Zero bits leave the latch untouched. Offset 0x18 reads the latch. If a detection and a clear hit the same cycle, the detection wins.
- R8: Writing ones to offset 0x15 sets enable bits, and writing ones to offset 0x16 clears them. Zero bits have no effect. Reads of 0x15 and 0x16 both return the enable mask.
- R9: `irq_req` is high one cycle after any bit is both latched and enabled, and is low otherwise.
- R10: A write of 0x14 directly followed by a write of 0x15 with the same mask enables a source without raising `irq_req` for a stale latch.
- R11: A source with neither side enabled never latches.
- R12: Reads of any offset not listed above return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_re` |
| irq_in | input | 8 | Raw interrupt source inputs |
| irq_req | output | 1 | Pending request toward the arbiter |

## Verification
The sources are programmed with a mix of types and sides: edge with both sides, edge high only, edge low only, edge with neither side, and level with each of the four side combinations. The inputs are then stepped through all-low, a low-nibble rise, a fall, and a high-nibble rise. After each step the latch pattern shows which detector fired on which transition. Clears are issued while a level persists and after it has gone, which separates a sticky edge latch from a re-arming level latch. An enable is applied with and without a preceding clear, which shows whether a stale latch leaks into the request.

// File: rtl/pir_pkg.sv
package pir_pkg;
  localparam logic [7:0] OFF_LIVE  = 8'h10;
  localparam logic [7:0] OFF_TYPE  = 8'h11;
  localparam logic [7:0] OFF_PHI   = 8'h12;
  localparam logic [7:0] OFF_PLO   = 8'h13;
  localparam logic [7:0] OFF_LCLR  = 8'h14;
  localparam logic [7:0] OFF_ENSET = 8'h15;
  localparam logic [7:0] OFF_ENCLR = 8'h16;
  localparam logic [7:0] OFF_LSTS  = 8'h18;
endpackage

// File: rtl/pir_input_stage.sv
module pir_input_stage #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] level,
  output logic [NSRC-1:0] rise,
  output logic [NSRC-1:0] fall
);
  logic [NSRC-1:0] cur_q, old_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0;
      old_q <= '0;
    end else begin
      cur_q <= raw;
      old_q <= cur_q;
    end
  end

  assign level = cur_q;
  assign rise  = cur_q & ~old_q;
  assign fall  = ~cur_q & old_q;
endmodule

// File: rtl/pir_latch.sv
module pir_latch #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] level,
  input  logic [NSRC-1:0] rise,
  input  logic [NSRC-1:0] fall,
  input  logic [NSRC-1:0] edge_mode,
  input  logic [NSRC-1:0] pol_hi,
  input  logic [NSRC-1:0] pol_lo,
  input  logic [NSRC-1:0] clr_mask,
  output logic [NSRC-1:0] set_ev,
  output logic [NSRC-1:0] lat
);
  logic [NSRC-1:0] lat_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic hit_edge, hit_lvl;
    assign hit_edge  = (pol_hi[i] & rise[i]) | (pol_lo[i] & fall[i]);
    assign hit_lvl   = (pol_hi[i] & level[i]) | (pol_lo[i] & ~level[i]);
    assign set_ev[i] = edge_mode[i] ? hit_edge : hit_lvl;

    always_ff @(posedge clk) begin
      if (rst) lat_q[i] <= 1'b0;
      else     lat_q[i] <= (lat_q[i] & ~clr_mask[i]) | set_ev[i];
    end
  end

  assign lat = lat_q;
endmodule

// File: rtl/pir_regs.sv
module pir_regs #(
  parameter int NSRC   = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSRC-1:0]   wdata,
  input  logic [NSRC-1:0]   level,
  input  logic [NSRC-1:0]   lat,
  output logic [NSRC-1:0]   edge_mode,
  output logic [NSRC-1:0]   pol_hi,
  output logic [NSRC-1:0]   pol_lo,
  output logic [NSRC-1:0]   en,
  output logic [NSRC-1:0]   clr_mask,
  output logic [NSRC-1:0]   rdata
);
  import pir_pkg::*;

  logic [NSRC-1:0] type_q, phi_q, plo_q, en_q, rd_q, rd_mux;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      type_q <= '0;
      phi_q  <= '0;
      plo_q  <= '0;
      en_q   <= '0;
    end else if (we) begin
      if (hit(addr, OFF_TYPE))  type_q <= wdata;
      if (hit(addr, OFF_PHI))   phi_q  <= wdata;
      if (hit(addr, OFF_PLO))   plo_q  <= wdata;
      if (hit(addr, OFF_ENSET)) en_q   <= en_q | wdata;
      if (hit(addr, OFF_ENCLR)) en_q   <= en_q & ~wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if      (hit(addr, OFF_LIVE))  rd_mux = level;
    else if (hit(addr, OFF_TYPE))  rd_mux = type_q;
    else if (hit(addr, OFF_PHI))   rd_mux = phi_q;
    else if (hit(addr, OFF_PLO))   rd_mux = plo_q;
    else if (hit(addr, OFF_ENSET)) rd_mux = en_q;
    else if (hit(addr, OFF_ENCLR)) rd_mux = en_q;
    else if (hit(addr, OFF_LSTS))  rd_mux = lat;
  end

  always_ff @(posedge clk) begin
    if (rst)     rd_q <= '0;
    else if (re) rd_q <= rd_mux;
  end

  assign clr_mask  = (we && hit(addr, OFF_LCLR)) ? wdata : '0;
  assign edge_mode = type_q;
  assign pol_hi    = phi_q;
  assign pol_lo    = plo_q;
  assign en        = en_q;
  assign rdata     = rd_q;
endmodule

// File: rtl/pir_block.sv
module pir_block #(
  parameter int NSRC   = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NSRC-1:0]   reg_wdata,
  output logic [NSRC-1:0]   reg_rdata,
  input  logic [NSRC-1:0]   irq_in,
  output logic              irq_req
);
  logic [NSRC-1:0] level, rise, fall;
  logic [NSRC-1:0] edge_mode, pol_hi, pol_lo, en_q, clr_mask;
  logic [NSRC-1:0] set_ev, lat_q;
  logic            req_q;

  pir_input_stage #(.NSRC(NSRC)) u_in (
    .clk(clk), .rst(rst), .raw(irq_in),
    .level(level), .rise(rise), .fall(fall)
  );

  pir_latch #(.NSRC(NSRC)) u_lat (
    .clk(clk), .rst(rst), .level(level), .rise(rise), .fall(fall),
    .edge_mode(edge_mode), .pol_hi(pol_hi), .pol_lo(pol_lo),
    .clr_mask(clr_mask), .set_ev(set_ev), .lat(lat_q)
  );

  pir_regs #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .re(reg_re), .addr(reg_addr),
    .wdata(reg_wdata), .level(level), .lat(lat_q),
    .edge_mode(edge_mode), .pol_hi(pol_hi), .pol_lo(pol_lo),
    .en(en_q), .clr_mask(clr_mask), .rdata(reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= |(lat_q & en_q);
  end

  assign irq_req = req_q;
endmodule

// File: rtl/pir_block_chk.sv
module pir_block_chk #(
  parameter int NSRC   = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [NSRC-1:0]   wdata,
  input logic [NSRC-1:0]   en,
  input logic [NSRC-1:0]   lat,
  input logic [NSRC-1:0]   set_ev,
  input logic [NSRC-1:0]   pol_hi,
  input logic [NSRC-1:0]   pol_lo,
  input logic              irq_req
);
  import pir_pkg::*;

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !irq_req); // R1

  AST_REQ_RISE: assert property (@(posedge clk) disable iff (rst)
    ((lat & en) != '0) |=> irq_req); // R9

  AST_REQ_FALL: assert property (@(posedge clk) disable iff (rst)
    ((lat & en) == '0) |=> !irq_req); // R9

  AST_LCLR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (we && addr == ADDR_W'(OFF_LCLR)) |=>
      ((lat & $past(wdata) & ~$past(set_ev)) == '0)); // R7

  AST_ENSET_WORKS: assert property (@(posedge clk) disable iff (rst)
    (we && addr == ADDR_W'(OFF_ENSET)) |=> ((en & $past(wdata)) == $past(wdata))); // R8

  AST_ENCLR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (we && addr == ADDR_W'(OFF_ENCLR)) |=> ((en & $past(wdata)) == '0)); // R8

  AST_NO_SIDE_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
    ((set_ev & ~(pol_hi | pol_lo)) == '0)); // R11
endmodule

bind pir_block pir_block_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
  .en(en_q), .lat(lat_q), .set_ev(set_ev), .pol_hi(pol_hi), .pol_lo(pol_lo),
  .irq_req(irq_req)
);

// File: tb/pir_block_test.sv
module pir_block_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0, irq_in = '0;
  logic [7:0] reg_rdata;
  logic       irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic [7:0] exp;
  } exp_t;
  exp_t sb[$];
  logic rd_fire = 1'b0;

  always #2 clk = ~clk;

  pir_block uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_in(irq_in), .irq_req(irq_req)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    exp_t e;
    e.tag = tag; e.exp = exp;
    sb.push_back(e);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) rd_fire <= reg_re;

  always @(negedge clk) begin
    if (rd_fire) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard underrun got %02h expected none", reg_rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, reg_rdata, e.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got hang expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 irq_req", {7'd0, irq_req}, 8'h00);
    rd(8'h11, 8'h00, "R1 type");
    rd(8'h12, 8'h00, "R1 pol_hi");
    rd(8'h13, 8'h00, "R1 pol_lo");
    rd(8'h15, 8'h00, "R1 enable");
    rd(8'h18, 8'h00, "R1 latch");
    // R2: live status
    irq_in = 8'hA5; idle(3);
    rd(8'h10, 8'hA5, "R2 live");
    irq_in = 8'h00; idle(3);
    rd(8'h10, 8'h00, "R2 live low");
    // R11: no side enabled, toggles leave no latch
    rd(8'h18, 8'h00, "R11 no latch");
    // R12: unmapped offsets
    rd(8'h17, 8'h00, "R12 unmapped 17");
    rd(8'h14, 8'h00, "R12 clear reg reads zero");
    // R3: configuration
    wr(8'h11, 8'h0F);
    wr(8'h12, 8'h33);
    wr(8'h13, 8'h55);
    rd(8'h11, 8'h0F, "R3 type");
    rd(8'h12, 8'h33, "R3 pol_hi");
    rd(8'h13, 8'h55, "R3 pol_lo");
    idle(2);
    // R6: level low-side sources 4 and 6 latch on low input
    rd(8'h18, 8'h50, "R6 level low latch");
    wr(8'h14, 8'h50); idle(2);
    rd(8'h18, 8'h50, "R6 reassert while level holds");
    // R4: rising low nibble, only high-side edge sources 0 and 1
    irq_in = 8'h0F; idle(4);
    rd(8'h18, 8'h53, "R4 rising edge");
    // R7: partial clear
    wr(8'h14, 8'h03); idle(1);
    rd(8'h18, 8'h50, "R7 clear ones");
    // R5: falling low nibble, low-side edge sources 0 and 2
    irq_in = 8'h00; idle(4);
    rd(8'h18, 8'h55, "R5 falling edge both sides");
    // R6: high nibble goes high, source 5 latches by high level
    irq_in = 8'hF0; idle(4);
    rd(8'h18, 8'h75, "R6 level high latch");
    wr(8'h14, 8'hFF); idle(2);
    rd(8'h18, 8'h30, "R6 release after level gone");
    wr(8'h14, 8'h00); idle(1);
    rd(8'h18, 8'h30, "R7 zero write no effect");
    // R8 / R9: enables and request
    wr(8'h15, 8'h01); idle(3);
    rd(8'h15, 8'h01, "R8 enable set");
    check("R9 masked no req", {7'd0, irq_req}, 8'h00);
    wr(8'h15, 8'h10); idle(3);
    check("R9 req high", {7'd0, irq_req}, 8'h01);
    rd(8'h16, 8'h11, "R8 enable mask via clear offset");
    wr(8'h16, 8'h10); idle(3);
    check("R9 req low after disable", {7'd0, irq_req}, 8'h00);
    wr(8'h15, 8'h00); wr(8'h16, 8'h00); idle(1);
    rd(8'h15, 8'h01, "R8 zero writes no effect");
    // R10: stale latch on source 1, cleared before enable
    irq_in = 8'hF2; idle(4);
    irq_in = 8'hF0; idle(4);
    rd(8'h18, 8'h32, "R4 stale latch src1");
    check("R9 stale masked", {7'd0, irq_req}, 8'h00);
    wr(8'h14, 8'h02);
    wr(8'h15, 8'h02);
    for (int k = 0; k < 5; k++) begin
      check("R10 no spurious req", {7'd0, irq_req}, 8'h00);
      @(negedge clk);
    end
    rd(8'h15, 8'h03, "R10 enabled after sequence");
    irq_in = 8'hF2; idle(4);
    check("R9 fresh event req", {7'd0, irq_req}, 8'h01);
    idle(4);
    check("R1 scoreboard drained", 8'(sb.size()), 8'h00);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule